// File: doc/BRIEF.md
# Sample FIFO with Almost-Full Interrupt

This block buffers 16-bit sensor samples between a conversion engine and a host. The engine offers one sample per `smp_valid` pulse. The host reaches the buffer through a byte-wide register strobe interface. The host programs a watermark that sets how close to full the buffer may get before an almost-full status bit is raised. It also chooses what happens to samples that arrive when every slot is taken: they either replace the oldest stored sample or are thrown away.

The host learns the buffer state in one of two ways. It can read the write and read pointers and derive the occupancy from them, or it can read the occupancy and the count of lost samples directly. The almost-full bit is cleared by reading the status register. In the per-sample mode it comes back on every new sample while the condition lasts. In the crossing mode it comes back only when the condition has gone away and then returns. The bit drives an active-low, level-sensitive interrupt line when two other settings allow it: the interrupt enable is set and the pin function is set to interrupt.

A sample is read as two bytes. Reading the high byte removes the sample from the buffer and holds its low byte for a following read.

Top module: `smpq_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, which includes the pointers, occupancy, lost-sample count, status, watermark, mode, enable and pin function. `irq_n` is 1.
- R2: Samples come out in the order they were accepted. Reading address 0x9 removes the oldest sample and returns bits 15:8. Address 0xA then returns bits 7:0 of that same sample and has no side effect. Register read data appears on `reg_rdata` one clock after the read strobe.
- R3: The write pointer (address 0x5) and read pointer (address 0x6) are 5 bits wide and wrap modulo 32. The occupancy (address 0x8) ranges from 0 to 32. When the buffer is full it reads 32 while the two pointers are equal.
- R4: Rollover is mode bit 0 at address 0x4. With rollover clear, a sample that arrives when the buffer is full is discarded and leaves the pointers, the occupancy and the stored samples unchanged.
- R5: With rollover set, a sample that arrives when the buffer is full overwrites the oldest entry, and both pointers advance by one.
- R6: The lost-sample count (address 0x7) rises by one for each sample that is discarded or overwritten. It saturates at 31 and returns to 0 when a sample is removed.
- R7: Reading address 0x9 while the buffer is empty returns 0, makes address 0xA return 0, and leaves the pointers unchanged.
- R8: When a sample arrives and a non-empty buffer is read in the same cycle, both take effect and the occupancy stays the same.
- R9: The watermark is bits 4:0 at address 0x3. The almost-full condition holds when the occupancy is at least 32 minus the watermark. For example, a watermark of 2 gives the condition from the 30th stored sample on.
- R10: Mode bit 1 at address 0x4 selects the assertion mode. When it is 0, every arriving sample after which the condition holds sets the status bit, including after the bit has been cleared.
- R11: When mode bit 1 is 1, the status bit is set only when the condition changes from false to true. After a clearing read it stays 0 while the condition persists.
- R12: The status register is address 0x0, with the almost-full bit in bit 0. Reading it returns the bit's value and then clears the bit, unless a new setting event happens in the same cycle. In that case the bit stays set.
- R13: `irq_n` is 0 exactly while three things hold: the status bit is 1, enable bit 0 at address 0x1 is 1, and the pin function in bits 1:0 at address 0x2 is 3. `irq_n` returns to 1 in the cycle after a clearing status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe offering a new sample |
| smp_data | input | 16 | Sample value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid one clock after `reg_rd` |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
Two pairs of operations can land in the same clock.

The first pair is an arriving sample and a status read. The bench drives the sample strobe and the status read strobe on the same edge, with the buffer already past the watermark. The read must return the old value of 1, and a second read must still find the bit set, because the new sample's setting event overrides the clear.

The second pair is a sample write and a sample read. The bench drives both on the same edge against a partly filled buffer. It checks that the oldest value is returned, that the occupancy is unchanged, and that the new sample appears last when the buffer is drained.

// File: rtl/smpq_pkg.sv
// Shared constants for the sample FIFO: register addresses, byte width and
// the pin-function code that routes the almost-full bit to the interrupt line.
package smpq_pkg;
    localparam int ADDR_W = 4;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] A_STATUS  = 4'h0;
    localparam logic [ADDR_W-1:0] A_IRQ_EN  = 4'h1;
    localparam logic [ADDR_W-1:0] A_PIN_FN  = 4'h2;
    localparam logic [ADDR_W-1:0] A_WMARK   = 4'h3;
    localparam logic [ADDR_W-1:0] A_MODE    = 4'h4;
    localparam logic [ADDR_W-1:0] A_WR_PTR  = 4'h5;
    localparam logic [ADDR_W-1:0] A_RD_PTR  = 4'h6;
    localparam logic [ADDR_W-1:0] A_LOST    = 4'h7;
    localparam logic [ADDR_W-1:0] A_OCC     = 4'h8;
    localparam logic [ADDR_W-1:0] A_DATA_HI = 4'h9;
    localparam logic [ADDR_W-1:0] A_DATA_LO = 4'hA;

    localparam logic [1:0] PIN_FN_IRQ = 2'd3;
endpackage

// File: rtl/smpq_store.sv
// Sample storage with write/read pointers, occupancy and lost-sample counter.
// Assumes DEPTH is a power of two (pointer distance equals occupancy mod DEPTH).
// A pop on an empty store is ignored and pop_data reads 0. A push into a full
// store overwrites the oldest entry when rollover is set, otherwise it is dropped.
module smpq_store #(
    parameter  int DEPTH = 32,
    parameter  int DW    = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [DW-1:0]    push_data_i,
    input  logic             pop_i,
    input  logic             rollover_i,
    output logic [DW-1:0]    pop_data_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [CNT_W-1:0] occ_o,
    output logic [CNT_W-1:0] occ_nxt_o,
    output logic [PTR_W-1:0] lost_o
);
    localparam logic [CNT_W-1:0] OCC_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LOST_MAX = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] occ_q, occ_d;
    logic [PTR_W-1:0] lost_q;
    logic             full, empty, pop_ok, push_room, push_ovw, push_drop, wr_en;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    // Classify this cycle's push and pop against the current occupancy.
    always_comb begin
        full      = (occ_q == OCC_FULL);
        empty     = (occ_q == '0);
        pop_ok    = pop_i && !empty;
        push_room = push_i && (!full || pop_ok);
        push_ovw  = push_i && full && !pop_ok && rollover_i;
        push_drop = push_i && full && !pop_ok && !rollover_i;
        wr_en     = push_room || push_ovw;
    end

    // Next occupancy: only a push into free space or a lone pop changes it.
    always_comb begin
        occ_d = occ_q;
        if (push_room && !pop_ok)      occ_d = occ_q + CNT_W'(1);
        else if (pop_ok && !push_room) occ_d = occ_q - CNT_W'(1);
    end

    // Sample array write port; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr_q] <= push_data_i;
    end

    // Pointer and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
        end else begin
            if (wr_en)             wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (pop_ok || push_ovw) rd_ptr_q <= ptr_inc(rd_ptr_q);
            occ_q <= occ_d;
        end
    end

    // Lost-sample counter: saturating, cleared by a successful pop.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          lost_q <= '0;
        else if (pop_ok)                                     lost_q <= '0;
        else if ((push_ovw || push_drop) && lost_q != LOST_MAX) lost_q <= lost_q + PTR_W'(1);
    end

    assign pop_data_o = empty ? '0 : mem[rd_ptr_q];
    assign wr_ptr_o   = wr_ptr_q;
    assign rd_ptr_o   = rd_ptr_q;
    assign occ_o      = occ_q;
    assign occ_nxt_o  = occ_d;
    assign lost_o     = lost_q;

    AST_OCC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_FULL);                                                   // R3
    AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(wr_ptr_q - rd_ptr_q) == PTR_W'(occ_q));                         // R3
    AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && full && !pop_i && !rollover_i |=> $stable(wr_ptr_q) && $stable(rd_ptr_q) && $stable(occ_q)); // R4
    AST_OVW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && full && !pop_i && rollover_i |=> rd_ptr_q == ptr_inc($past(rd_ptr_q)) && occ_q == OCC_FULL); // R5
    AST_LOST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        lost_q == LOST_MAX && !pop_i |=> lost_q == LOST_MAX);                  // R6
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && occ_q == '0 |=> $stable(rd_ptr_q));                           // R7
    AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && pop_i && occ_q != '0 |=> $stable(occ_q));                    // R8
endmodule

// File: rtl/smpq_flag.sv
// Almost-full status bit and interrupt gating.
// The condition is evaluated on the occupancy as it will be after this cycle.
// In per-sample mode each arriving sample re-sets the bit while the condition
// holds; in crossing mode only a false-to-true change of the condition sets it.
// A setting event in the same cycle as a clearing read wins.
module smpq_flag #(
    parameter  int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    input  logic [CNT_W-1:0] occ_nxt_i,
    input  logic [PTR_W-1:0] wmark_i,
    input  logic             edge_mode_i,
    input  logic             clr_i,
    input  logic             irq_en_i,
    input  logic [1:0]       pin_fn_i,
    output logic             flag_o,
    output logic             irq_n_o
);
    import smpq_pkg::*;

    logic [CNT_W-1:0] thresh;
    logic             cond_nxt, cond_q, set_evt, flag_q;

    // Threshold and the post-update almost-full condition.
    always_comb begin
        thresh   = CNT_W'(DEPTH) - CNT_W'(wmark_i);
        cond_nxt = (occ_nxt_i >= thresh);
        set_evt  = edge_mode_i ? (cond_nxt && !cond_q) : (sample_i && cond_nxt);
    end

    // Condition history and the status bit itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            cond_q <= cond_nxt;
            if (set_evt)    flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
        end
    end

    assign flag_o  = flag_q;
    assign irq_n_o = !(flag_q && irq_en_i && (pin_fn_i == PIN_FN_IRQ));

    AST_FLAG_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_q && !cond_nxt |=> !flag_q);                                     // R9
    AST_EDGE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode_i && cond_q && cond_nxt && !flag_q |=> !flag_q);             // R11
    AST_LEVEL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode_i && sample_i && cond_nxt |=> flag_q);                      // R10
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !sample_i && !edge_mode_i |=> !flag_q);                       // R12
endmodule

// File: rtl/smpq_regs.sv
// Register file and read path. Holds the configuration fields, turns reads of
// the status and data-high addresses into clear and pop strobes, and keeps the
// low byte of the last popped sample. Read data is registered (one-clock latency).
// Assumes a sample is exactly two bytes wide.
module smpq_regs #(
    parameter  int DEPTH = 32,
    parameter  int DW    = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr_i,
    input  logic                          reg_rd_i,
    input  logic [smpq_pkg::ADDR_W-1:0]   reg_addr_i,
    input  logic [smpq_pkg::BYTE_W-1:0]   reg_wdata_i,
    output logic [smpq_pkg::BYTE_W-1:0]   reg_rdata_o,
    input  logic [PTR_W-1:0]              wr_ptr_i,
    input  logic [PTR_W-1:0]              rd_ptr_i,
    input  logic [CNT_W-1:0]              occ_i,
    input  logic [PTR_W-1:0]              lost_i,
    input  logic [DW-1:0]                 pop_data_i,
    input  logic                          flag_i,
    output logic                          pop_o,
    output logic                          clr_o,
    output logic [PTR_W-1:0]              wmark_o,
    output logic                          rollover_o,
    output logic                          edge_mode_o,
    output logic                          irq_en_o,
    output logic [1:0]                    pin_fn_o
);
    import smpq_pkg::*;

    logic [PTR_W-1:0]  wmark_q;
    logic              rollover_q, edge_mode_q, irq_en_q;
    logic [1:0]        pin_fn_q;
    logic [BYTE_W-1:0] lo_hold_q, rdata_q;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata_i[BYTE_W-1:PTR_W];

    // Side-effect strobes decoded from the read address.
    assign pop_o = reg_rd_i && (reg_addr_i == A_DATA_HI);
    assign clr_o = reg_rd_i && (reg_addr_i == A_STATUS);

    // Configuration field writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wmark_q     <= '0;
            rollover_q  <= 1'b0;
            edge_mode_q <= 1'b0;
            irq_en_q    <= 1'b0;
            pin_fn_q    <= '0;
        end else if (reg_wr_i) begin
            case (reg_addr_i)
                A_IRQ_EN: irq_en_q <= reg_wdata_i[0];
                A_PIN_FN: pin_fn_q <= reg_wdata_i[1:0];
                A_WMARK:  wmark_q  <= reg_wdata_i[PTR_W-1:0];
                A_MODE: begin
                    rollover_q  <= reg_wdata_i[0];
                    edge_mode_q <= reg_wdata_i[1];
                end
                default: ;
            endcase
        end
    end

    // Low-byte holding register, loaded on every data-high read.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_hold_q <= '0;
        else if (pop_o) lo_hold_q <= pop_data_i[BYTE_W-1:0];
    end

    // Registered read multiplexer.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (reg_rd_i) begin
            case (reg_addr_i)
                A_STATUS:  rdata_q <= BYTE_W'(flag_i);
                A_IRQ_EN:  rdata_q <= BYTE_W'(irq_en_q);
                A_PIN_FN:  rdata_q <= BYTE_W'(pin_fn_q);
                A_WMARK:   rdata_q <= BYTE_W'(wmark_q);
                A_MODE:    rdata_q <= BYTE_W'({edge_mode_q, rollover_q});
                A_WR_PTR:  rdata_q <= BYTE_W'(wr_ptr_i);
                A_RD_PTR:  rdata_q <= BYTE_W'(rd_ptr_i);
                A_LOST:    rdata_q <= BYTE_W'(lost_i);
                A_OCC:     rdata_q <= BYTE_W'(occ_i);
                A_DATA_HI: rdata_q <= pop_data_i[DW-1:BYTE_W];
                A_DATA_LO: rdata_q <= lo_hold_q;
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata_o = rdata_q;
    assign wmark_o     = wmark_q;
    assign rollover_o  = rollover_q;
    assign edge_mode_o = edge_mode_q;
    assign irq_en_o    = irq_en_q;
    assign pin_fn_o    = pin_fn_q;

    AST_STATUS_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_i && reg_addr_i == A_STATUS |=> reg_rdata_o == BYTE_W'($past(flag_i))); // R12
endmodule

// File: rtl/smpq_top.sv
// Sample FIFO top: connects storage, almost-full flag logic and the register
// file. Samples enter on smp_valid; the host reads and configures through a
// byte-wide strobe interface with one-clock read latency.
module smpq_top #(
    parameter  int DEPTH    = 32,
    parameter  int SAMPLE_W = 16,
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CNT_W    = PTR_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        smp_valid,
    input  logic [SAMPLE_W-1:0]         smp_data,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [smpq_pkg::ADDR_W-1:0] reg_addr,
    input  logic [smpq_pkg::BYTE_W-1:0] reg_wdata,
    output logic [smpq_pkg::BYTE_W-1:0] reg_rdata,
    output logic                        irq_n
);
    import smpq_pkg::*;

    logic [SAMPLE_W-1:0] pop_data;
    logic [PTR_W-1:0]    wr_ptr, rd_ptr, lost, wmark;
    logic [CNT_W-1:0]    occ, occ_nxt;
    logic                pop, clr, flag, rollover, edge_mode, irq_en;
    logic [1:0]          pin_fn;

    smpq_store #(.DEPTH(DEPTH), .DW(SAMPLE_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (smp_valid),
        .push_data_i (smp_data),
        .pop_i       (pop),
        .rollover_i  (rollover),
        .pop_data_o  (pop_data),
        .wr_ptr_o    (wr_ptr),
        .rd_ptr_o    (rd_ptr),
        .occ_o       (occ),
        .occ_nxt_o   (occ_nxt),
        .lost_o      (lost)
    );

    smpq_flag #(.DEPTH(DEPTH)) u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_i    (smp_valid),
        .occ_nxt_i   (occ_nxt),
        .wmark_i     (wmark),
        .edge_mode_i (edge_mode),
        .clr_i       (clr),
        .irq_en_i    (irq_en),
        .pin_fn_i    (pin_fn),
        .flag_o      (flag),
        .irq_n_o     (irq_n)
    );

    smpq_regs #(.DEPTH(DEPTH), .DW(SAMPLE_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .wr_ptr_i    (wr_ptr),
        .rd_ptr_i    (rd_ptr),
        .occ_i       (occ),
        .lost_i      (lost),
        .pop_data_i  (pop_data),
        .flag_i      (flag),
        .pop_o       (pop),
        .clr_o       (clr),
        .wmark_o     (wmark),
        .rollover_o  (rollover),
        .edge_mode_o (edge_mode),
        .irq_en_o    (irq_en),
        .pin_fn_o    (pin_fn)
    );

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_fn != PIN_FN_IRQ || !irq_en) |-> irq_n);                          // R13
    AST_IRQ_DROPS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !smp_valid && !edge_mode |=> irq_n);                            // R13
endmodule

// File: tb/smpq_top_bench.sv
module smpq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    smpq_top u_smpq_top (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    function automatic logic [15:0] pat(input int i);
        return 16'(16'hA5C3 ^ (i * 16'h0159));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic push(input logic [15:0] d);
        @(negedge clk); smp_valid = 1'b1; smp_data = d;
        @(negedge clk); smp_valid = 1'b0;
    endtask

    task automatic rreg(input logic [3:0] a, output int v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0;
        v = int'(reg_rdata);
    endtask

    task automatic wreg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic pop_chk(input string tag, input logic [15:0] exp);
        int hi, lo;
        rreg(4'h9, hi);
        rreg(4'hA, lo);
        chk(tag, (hi << 8) | lo, int'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        do_reset();
        // R1: every register reads zero after reset
        chk("R1 irq_n", int'(irq_n), 1);
        for (int a = 0; a <= 10; a++) begin
            rreg(4'(a), v);
            chk($sformatf("R1 addr %0d", a), v, 0);
        end

        // R2 ordering and R3 pointer wrap over two rounds of 20
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 20; i++) push(pat(r * 20 + i));
            for (int i = 0; i < 20; i++) pop_chk("R2 order", pat(r * 20 + i));
        end
        rreg(4'h5, v); chk("R3 wr_ptr wrap", v, 40 % 32);
        rreg(4'h6, v); chk("R3 rd_ptr wrap", v, 40 % 32);

        // R3 full versus empty, R4 drop, R6 saturation and clear
        do_reset();
        for (int i = 0; i < 32; i++) push(pat(i));
        rreg(4'h8, v); chk("R3 occ full", v, 32);
        rreg(4'h5, v); chk("R3 wr_ptr full", v, 0);
        rreg(4'h6, v); chk("R3 rd_ptr full", v, 0);
        for (int i = 0; i < 5; i++) push(pat(100 + i));
        rreg(4'h7, v); chk("R6 lost count", v, 5);
        rreg(4'h5, v); chk("R4 wr_ptr held", v, 0);
        rreg(4'h8, v); chk("R4 occ held", v, 32);
        for (int i = 0; i < 35; i++) push(pat(200 + i));
        rreg(4'h7, v); chk("R6 lost saturates", v, 31);
        pop_chk("R4 oldest kept", pat(0));
        rreg(4'h7, v); chk("R6 lost cleared", v, 0);
        rreg(4'h8, v); chk("R4 occ after pop", v, 31);

        // R5 rollover overwrite
        do_reset();
        wreg(4'h4, 8'h01);
        for (int i = 0; i < 32; i++) push(pat(i));
        for (int j = 0; j < 3; j++) push(pat(300 + j));
        rreg(4'h6, v); chk("R5 rd_ptr advanced", v, 3);
        rreg(4'h5, v); chk("R5 wr_ptr advanced", v, 3);
        rreg(4'h7, v); chk("R6 lost on overwrite", v, 3);
        for (int i = 3; i < 32; i++) pop_chk("R5 survivors", pat(i));
        for (int j = 0; j < 3; j++) pop_chk("R5 newest", pat(300 + j));

        // R7 empty read
        rreg(4'h9, v); chk("R7 empty hi", v, 0);
        rreg(4'hA, v); chk("R7 empty lo", v, 0);
        rreg(4'h6, v); chk("R7 rd_ptr unchanged", v, 3);

        // R8 push and pop in the same cycle
        for (int i = 0; i < 5; i++) push(pat(50 + i));
        @(negedge clk); smp_valid = 1'b1; smp_data = pat(60); reg_rd = 1'b1; reg_addr = 4'h9;
        @(negedge clk); smp_valid = 1'b0; reg_rd = 1'b0;
        chk("R8 popped oldest hi", int'(reg_rdata), int'(pat(50) >> 8));
        rreg(4'h8, v); chk("R8 occ unchanged", v, 5);
        for (int i = 1; i < 5; i++) pop_chk("R8 order", pat(50 + i));
        pop_chk("R8 pushed last", pat(60));

        // R9/R10 sweep of every watermark in per-sample mode
        for (int wm = 0; wm < 32; wm++) begin
            do_reset();
            wreg(4'h3, 8'(wm));
            for (int n = 1; n <= 32; n++) begin
                push(pat(n));
                rreg(4'h0, v);
                chk($sformatf("R9 R10 wm=%0d n=%0d", wm, n), v, (n >= 32 - wm) ? 1 : 0);
            end
        end

        // R11 crossing mode, watermark 2
        do_reset();
        wreg(4'h3, 8'd2);
        wreg(4'h4, 8'h02);
        for (int n = 1; n <= 32; n++) begin
            push(pat(n));
            rreg(4'h0, v);
            chk($sformatf("R11 n=%0d", n), v, (n == 30) ? 1 : 0);
        end
        for (int i = 0; i < 3; i++) rreg(4'h9, v);
        rreg(4'h0, v); chk("R11 below watermark", v, 0);
        push(pat(77));
        rreg(4'h0, v); chk("R11 fresh crossing", v, 1);
        push(pat(78));
        rreg(4'h0, v); chk("R11 no repeat", v, 0);

        // R12 sample and status read in the same cycle: set wins
        do_reset();
        wreg(4'h3, 8'd31);
        push(pat(1));
        @(negedge clk); smp_valid = 1'b1; smp_data = pat(2); reg_rd = 1'b1; reg_addr = 4'h0;
        @(negedge clk); smp_valid = 1'b0; reg_rd = 1'b0;
        chk("R12 read returns set", int'(reg_rdata), 1);
        rreg(4'h0, v); chk("R12 set beats clear", v, 1);
        rreg(4'h0, v); chk("R12 cleared", v, 0);

        // R13 interrupt gating and release
        do_reset();
        wreg(4'h3, 8'd31);
        wreg(4'h1, 8'h01);
        wreg(4'h2, 8'h03);
        push(pat(1));
        chk("R13 irq asserted", int'(irq_n), 0);
        rreg(4'h0, v);
        chk("R13 irq released by read", int'(irq_n), 1);
        wreg(4'h2, 8'h02);
        push(pat(2));
        chk("R13 pin function gates", int'(irq_n), 1);
        rreg(4'h0, v); chk("R13 status still set", v, 1);
        wreg(4'h2, 8'h03);
        wreg(4'h1, 8'h00);
        push(pat(3));
        chk("R13 enable gates", int'(irq_n), 1);
        wreg(4'h1, 8'h01);
        chk("R13 level follows enable", int'(irq_n), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule